// File: doc/BRIEF.md
# 4:2:2 MCU Block Reader

This block sits at the head of a JPEG-style encoding pipeline and pulls pixels for one 16x8 minimum coded unit at a time out of an eight-row line buffer. Every pixel it reads holds a luma byte and two chroma bytes. It walks the left 8x8 half of the unit in raster order, one pixel per accepted output slot, and then the right half. Each luma byte goes downstream as soon as it is read. The two chroma bytes are kept in a small local store.

Once both luma blocks have been sent, the block serves chroma from its local store and does not touch the line buffer. It sends one Cb block and then one Cr block. Each holds the even-column samples of the 16-pixel-wide unit, which is the 2:1 horizontal decimation of 4:2:2. Every output sample carries a component tag and a last-of-block flag. A valid/ready handshake lets the downstream FIFO pause the block at any cycle.

The sequencer has five states:
- `ST_WAIT`: idle, waiting for a unit. It moves to `ST_LUMA_L` when `unit_avail` is high and no output sample is pending.
- `ST_LUMA_L`: moves to `ST_LUMA_R` on its 64th issued sample.
- `ST_LUMA_R`: moves to `ST_CHR_B` on its 64th sample.
- `ST_CHR_B`: moves to `ST_CHR_R` on its 64th sample.
- `ST_CHR_R`: returns to `ST_WAIT` on its 64th sample and advances to the next unit position along the strip. Positions wrap after the last unit of the strip.

Top module: `mcu_reader`

## Requirements
- R1: After reset `o_valid` and `lb_rd_en` are low.
- R2: The first 64 samples of a unit carry tag 0 (Y1). Their data is the luma byte `lb_rd_data[23:16]` of line-buffer address `row*LINE_W + unit*16 + col`, for row 0..7 outer and col 0..7 inner.
- R3: The next 64 samples carry tag 1 (Y2). They use the same address pattern with col 8..15.
- R4: The next 64 samples carry tag 2 (Cb). Each is the byte `lb_rd_data[15:8]` of the pixel at unit column 2k, for row 0..7 outer and k 0..7 inner.
- R5: The final 64 samples of a unit carry tag 3 (Cr). Each is the byte `lb_rd_data[7:0]` of the same pixels, in the same order as R4.
- R6: `o_last` is high on the 64th sample of each block and on no other sample.
- R7: `lb_rd_en` stays low from the acceptance of the last Y2 sample until the acceptance of the last Cr sample.
- R8: While `o_valid` is high and `o_ready` is low, the output holds its data, tag and last flag. No sample is dropped or duplicated.
- R9: A unit starts reading only when `unit_avail` is high and the previous unit's last Cr sample has been accepted. The unit index steps by one per unit and wraps after `LINE_W/16` units.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| unit_avail | input | 1 | Line buffer holds the rows for the next unit |
| lb_rd_en | output | 1 | Line-buffer read strobe |
| lb_rd_addr | output | $clog2(8*LINE_W) | Line-buffer read address |
| lb_rd_data | input | 3*PW | Pixel {Y, Cb, Cr}; combinational response to `lb_rd_addr` |
| o_valid | output | 1 | Output sample valid |
| o_ready | input | 1 | Downstream can accept |
| o_tag | output | 2 | Component tag: 0 Y1, 1 Y2, 2 Cb, 3 Cr |
| o_last | output | 1 | 64th sample of a block |
| o_data | output | PW | Sample value |

## Verification
The line buffer answers in the same cycle as `lb_rd_addr`. An output sample is registered, so it appears one clock after the cycle in which its read or store lookup is issued. That issue happens only in a cycle where the output slot is empty or is being drained.

The bench does not count latency cycles. It compares every sample accepted at the handshake with the head of a queue of expected samples, so any added or missing register stage would show up as a wrong sequence. The bench drives `o_ready` half a cycle ahead of each rising edge and samples 1 ns later, still before that edge. Both the handshake check and the read-strobe checks (R7, R9) therefore see the exact values the design acts on at that edge.

// File: rtl/mcu_pkg.sv
package mcu_pkg;
    typedef enum logic [1:0] {
        TAG_Y1 = 2'd0,
        TAG_Y2 = 2'd1,
        TAG_CB = 2'd2,
        TAG_CR = 2'd3
    } comp_tag_t;

    typedef enum logic [2:0] {
        ST_WAIT,
        ST_LUMA_L,
        ST_LUMA_R,
        ST_CHR_B,
        ST_CHR_R
    } phase_t;

    localparam int BLK_DIM   = 8;
    localparam int BLK_PIX   = BLK_DIM * BLK_DIM;
    localparam int UNIT_W_PX = 2 * BLK_DIM;
    localparam int STORE_D   = 2 * BLK_PIX;
endpackage

// File: rtl/mcu_seq.sv
module mcu_seq
    import mcu_pkg::*;
#(
    parameter int LINE_W = 64
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              unit_avail,
    input  logic                              slot_free,
    input  logic                              out_pending,
    output logic                              step,
    output phase_t                            phase,
    output comp_tag_t                         tag,
    output logic                              blk_last,
    output logic                              lb_rd_en,
    output logic [$clog2(BLK_DIM*LINE_W)-1:0] lb_rd_addr,
    output logic                              st_wr_en,
    output logic [$clog2(STORE_D)-1:0]        st_wr_idx,
    output logic [$clog2(STORE_D)-1:0]        st_rd_idx
);
    localparam int ADDR_W = $clog2(BLK_DIM * LINE_W);
    localparam int CNT_W  = $clog2(BLK_PIX);
    localparam int RC_W   = $clog2(BLK_DIM);
    localparam int UNITS  = LINE_W / UNIT_W_PX;
    localparam int UNIT_W = (UNITS > 1) ? $clog2(UNITS) : 1;

    phase_t             phase_nx;
    logic [CNT_W-1:0]   cnt;
    logic [UNIT_W-1:0]  unit_idx;
    logic [RC_W-1:0]    row;
    logic [RC_W-1:0]    col;
    logic               cnt_end;
    logic               luma;

    assign row     = cnt[CNT_W-1:RC_W];
    assign col     = cnt[RC_W-1:0];
    assign cnt_end = (cnt == CNT_W'(BLK_PIX - 1));
    assign luma    = (phase == ST_LUMA_L) || (phase == ST_LUMA_R);

    always_ff @(posedge clk) begin
        if (!rst_n) phase <= ST_WAIT;
        else        phase <= phase_nx;
    end

    always_comb begin
        phase_nx = phase;
        unique case (phase)
            ST_WAIT:   if (unit_avail && !out_pending) phase_nx = ST_LUMA_L;
            ST_LUMA_L: if (step && cnt_end) phase_nx = ST_LUMA_R;
            ST_LUMA_R: if (step && cnt_end) phase_nx = ST_CHR_B;
            ST_CHR_B:  if (step && cnt_end) phase_nx = ST_CHR_R;
            ST_CHR_R:  if (step && cnt_end) phase_nx = ST_WAIT;
            default:   phase_nx = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            unit_idx <= '0;
        end else if (step) begin
            cnt <= cnt + 1'b1;
            if (phase == ST_CHR_R && cnt_end)
                unit_idx <= (unit_idx == UNIT_W'(UNITS - 1)) ? '0 : unit_idx + 1'b1;
        end
    end

    always_comb begin
        step     = (phase != ST_WAIT) && slot_free;
        lb_rd_en = step && luma;
        st_wr_en = lb_rd_en;
        blk_last = cnt_end;
        tag      = TAG_Y1;
        unique case (phase)
            ST_LUMA_R: tag = TAG_Y2;
            ST_CHR_B:  tag = TAG_CB;
            ST_CHR_R:  tag = TAG_CR;
            default:   tag = TAG_Y1;
        endcase
        lb_rd_addr = ADDR_W'(row) * ADDR_W'(LINE_W)
                   + ADDR_W'(unit_idx) * ADDR_W'(UNIT_W_PX)
                   + ((phase == ST_LUMA_R) ? ADDR_W'(BLK_DIM) : ADDR_W'(0))
                   + ADDR_W'(col);
        st_wr_idx  = {(phase == ST_LUMA_R), row, col};
        st_rd_idx  = {col[RC_W-1], row, col[RC_W-2:0], 1'b0};
    end

    AST_START_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_LUMA_L && cnt == '0 && step) |-> !out_pending); // R9

endmodule

// File: rtl/mcu_chroma_store.sv
module mcu_chroma_store
    import mcu_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic                       clk,
    input  logic                       wr_en,
    input  logic [$clog2(STORE_D)-1:0] wr_idx,
    input  logic [2*PW-1:0]            wr_chroma,
    input  logic [$clog2(STORE_D)-1:0] rd_idx,
    output logic [2*PW-1:0]            rd_chroma
);
    for (genvar p = 0; p < 2; p++) begin : g_plane
        logic [PW-1:0] mem [STORE_D];
        always_ff @(posedge clk) begin
            if (wr_en) mem[wr_idx] <= wr_chroma[p*PW +: PW];
        end
        assign rd_chroma[p*PW +: PW] = mem[rd_idx];
    end
endmodule

// File: rtl/mcu_out_stage.sv
module mcu_out_stage
    import mcu_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [PW-1:0]   in_data,
    input  comp_tag_t       in_tag,
    input  logic            in_last,
    input  logic            o_ready,
    output logic            slot_free,
    output logic            o_valid,
    output logic [PW-1:0]   o_data,
    output comp_tag_t       o_tag,
    output logic            o_last
);
    assign slot_free = !o_valid || o_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_valid <= 1'b0;
            o_data  <= '0;
            o_tag   <= TAG_Y1;
            o_last  <= 1'b0;
        end else if (load) begin
            o_valid <= 1'b1;
            o_data  <= in_data;
            o_tag   <= in_tag;
            o_last  <= in_last;
        end else if (o_ready) begin
            o_valid <= 1'b0;
        end
    end

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && !o_ready) |=> (o_valid && $stable(o_data) && $stable(o_tag) && $stable(o_last))); // R8

    AST_LAST_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && o_ready && o_last) |=> (!o_valid || !o_last)); // R6

endmodule

// File: rtl/mcu_reader.sv
module mcu_reader
    import mcu_pkg::*;
#(
    parameter int PW     = 8,
    parameter int LINE_W = 64
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              unit_avail,
    output logic                              lb_rd_en,
    output logic [$clog2(BLK_DIM*LINE_W)-1:0] lb_rd_addr,
    input  logic [3*PW-1:0]                   lb_rd_data,
    output logic                              o_valid,
    input  logic                              o_ready,
    output logic [1:0]                        o_tag,
    output logic                              o_last,
    output logic [PW-1:0]                     o_data
);
    localparam int IDX_W = $clog2(STORE_D);

    logic             step, slot_free, blk_last, st_wr_en;
    phase_t           phase;
    comp_tag_t        tag, tag_q;
    logic [IDX_W-1:0] st_wr_idx, st_rd_idx;
    logic [2*PW-1:0]  rd_chroma;
    logic [PW-1:0]    smp;

    mcu_seq #(.LINE_W(LINE_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .unit_avail(unit_avail),
        .slot_free(slot_free), .out_pending(o_valid),
        .step(step), .phase(phase), .tag(tag), .blk_last(blk_last),
        .lb_rd_en(lb_rd_en), .lb_rd_addr(lb_rd_addr),
        .st_wr_en(st_wr_en), .st_wr_idx(st_wr_idx), .st_rd_idx(st_rd_idx)
    );

    // plane 0 holds Cr, plane 1 holds Cb
    mcu_chroma_store #(.PW(PW)) u_store (
        .clk(clk), .wr_en(st_wr_en), .wr_idx(st_wr_idx),
        .wr_chroma(lb_rd_data[2*PW-1:0]),
        .rd_idx(st_rd_idx), .rd_chroma(rd_chroma)
    );

    always_comb begin
        unique case (phase)
            ST_CHR_B: smp = rd_chroma[2*PW-1:PW];
            ST_CHR_R: smp = rd_chroma[PW-1:0];
            default:  smp = lb_rd_data[3*PW-1:2*PW];
        endcase
    end

    mcu_out_stage #(.PW(PW)) u_out (
        .clk(clk), .rst_n(rst_n), .load(step), .in_data(smp),
        .in_tag(tag), .in_last(blk_last), .o_ready(o_ready),
        .slot_free(slot_free), .o_valid(o_valid), .o_data(o_data),
        .o_tag(tag_q), .o_last(o_last)
    );

    assign o_tag = tag_q;

    AST_CHROMA_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && (o_tag == TAG_CB || o_tag == TAG_CR)) |-> !lb_rd_en); // R7

endmodule

// File: tb/sim_mcu_reader.sv
`timescale 1ns/1ps
module sim_mcu_reader;
    localparam int PW = 8;
    localparam int LINE_W = 64;
    localparam int UNITS = LINE_W / 16;
    localparam int AW = $clog2(8 * LINE_W);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic unit_avail = 1'b0;
    logic lb_rd_en;
    logic [AW-1:0] lb_rd_addr;
    logic [3*PW-1:0] lb_rd_data;
    logic o_valid;
    logic o_ready = 1'b0;
    logic [1:0] o_tag;
    logic o_last;
    logic [PW-1:0] o_data;

    always #2 clk = ~clk;

    mcu_reader #(.PW(PW), .LINE_W(LINE_W)) u0 (
        .clk(clk), .rst_n(rst_n), .unit_avail(unit_avail),
        .lb_rd_en(lb_rd_en), .lb_rd_addr(lb_rd_addr), .lb_rd_data(lb_rd_data),
        .o_valid(o_valid), .o_ready(o_ready), .o_tag(o_tag),
        .o_last(o_last), .o_data(o_data)
    );

    function automatic logic [23:0] pix(input int a);
        logic [7:0] y, cb, cr;
        y  = 8'(a * 5 + ((a >> 8) & 1) * 77 + 11);
        cb = 8'(a * 3 + 7) ^ 8'(((a >> 8) & 1) << 7);
        cr = 8'(a * 11 + 200) ^ 8'((a >> 8) & 1);
        return {y, cb, cr};
    endfunction

    assign lb_rd_data = pix(int'(lb_rd_addr));

    int n_chk = 0, n_bad = 0;
    logic [10:0] exp_q[$];
    int ready_mode = 0;
    int units_done = 0;
    bit in_chroma = 1'b0;
    int chroma_reads = 0;
    bit done = 1'b0;
    int cyc = 0;

    function automatic string req_of(input logic [1:0] t);
        case (t)
            2'd0: return "R2";
            2'd1: return "R3";
            2'd2: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_unit(input int u);
        for (int t = 0; t < 4; t++)
            for (int r = 0; r < 8; r++)
                for (int k = 0; k < 8; k++) begin
                    int col, a;
                    logic [23:0] p;
                    logic [7:0] d;
                    col = (t == 0) ? k : (t == 1) ? k + 8 : 2 * k;
                    a = r * LINE_W + u * 16 + col;
                    p = pix(a);
                    d = (t < 2) ? p[23:16] : (t == 2) ? p[15:8] : p[7:0];
                    exp_q.push_back({2'(t), (r == 7 && k == 7), d});
                end
    endtask

    // ready driver and scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            cyc++;
            case (ready_mode)
                0: o_ready <= 1'b1;
                1: o_ready <= (($urandom % 10) < 7);
                default: o_ready <= ~o_ready;
            endcase
            #1;
            if (in_chroma && lb_rd_en) chroma_reads++;
            if (o_valid && o_tag == 2'd3 && o_last && lb_rd_en)
                check(1'b0, "R9 read before Cr last accepted", 1, 0);
            if (o_valid && o_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 extra sample", {o_tag, o_last, o_data}, 0);
                end else begin
                    logic [10:0] e;
                    e = exp_q.pop_front();
                    check({o_tag, o_last, o_data} == e, req_of(e[10:9]),
                          {o_tag, o_last, o_data}, e);
                    if (o_last != e[8]) check(1'b0, "R6 last flag", o_last, e[8]);
                end
                if (o_tag == 2'd1 && o_last) begin
                    in_chroma = 1'b1;
                    chroma_reads = 0;
                end
                if (o_tag == 2'd3 && o_last) begin
                    in_chroma = 1'b0;
                    check(chroma_reads == 0, "R7 reads in chroma phase", chroma_reads, 0);
                    units_done++;
                    ready_mode = units_done % 3;
                end
            end
            if (cyc > 100000) begin
                check(1'b0, "watchdog", cyc, 0);
                done = 1'b1;
            end
        end
    end

    initial begin
        int idle_hits;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(!o_valid, "R1 o_valid after reset", o_valid, 0);
        check(!lb_rd_en, "R1 lb_rd_en after reset", lb_rd_en, 0);
        idle_hits = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            #1;
            if (lb_rd_en || o_valid) idle_hits++;
        end
        check(idle_hits == 0, "R9 idle without unit_avail", idle_hits, 0);
        for (int u = 0; u < 6; u++) push_unit(u % UNITS); // R9 wrap of unit index
        unit_avail = 1'b1;
        while (exp_q.size() != 0 && !done) @(negedge clk);
        unit_avail = 1'b0;
        repeat (10) @(negedge clk);
        done = 1'b1;
        check(units_done == 6, "R9 unit count", units_done, 6);
        check(exp_q.size() == 0, "R8 missing samples", exp_q.size(), 0);
        #1;
        check(!o_valid, "R8 no duplicate after drain", o_valid, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule